// File: doc/BRIEF.md
# Flow Filter Command Sequencer

This block installs or removes one exact-match flow filter in the register file of a packet classifier. A host request carries the operation, the match fields and the placement data. The match fields are the IPv4 source and destination addresses, the two layer-4 ports, a flex word, a packet-type word, a flow type and a pool number. The placement data is a 13-bit bucket hash, a 16-bit software index and a receive queue. The sequencer turns the request into an ordered run of single-word transfers on a simple CSR bus. Each transfer holds its strobe until the target acknowledges it with ready, so every write is committed before the next one starts.

An add writes eight staging words and then the command word. It then reads the command register until the classifier reports that it is no longer busy. An erase works in two stages. It first writes the hash word and issues a query. When the query completes, the block inspects the filter-valid bit in the command register value that reported completion. Only if that bit is set does it rewrite the hash word, issue a remove command and wait for that command to complete too. At the end of every sequence the block pulses done for one cycle. The error flag beside done tells a normal end from a polling timeout.

Top module: `flt_cmd_seq`

## Requirements
- R1: After reset the block is idle: busy, done, csr_wr and csr_rd are all low.
- R2: An add writes, in this order and one transfer at a time, at word offsets 0x00 to 0x20 from the base address: three zero words (offsets 0x00, 0x04, 0x08), the source address (0x0C), the destination address (0x10), the port word (0x14), the flex word (0x18), the hash word (0x1C) and the command word (0x20).
- R3: The port word is {destination port, source port}, with the destination port in bits 31:16. The flex word is {flex bytes, packet type}, with the flex bytes in bits 31:16.
- R4: The hash word holds the bucket hash in bits 12:0, zeros in bits 14:13 and the software index in bits 31:16. Bit 15 (bucket valid) is 1 for an add and 0 for every hash write of an erase.
- R5: The add command word has opcode 1 in bits 1:0 and sets bit 3 (filter update), bit 11 (last) and bit 15 (queue enable). It carries the flow type in bits 7:5, the receive queue in bits 22:16 and the pool in bits 29:24. All other bits are zero except bit 9.
- R6: Bit 9 (drop) of the add command word is 1 exactly when the receive queue is 127.
- R7: An erase writes the hash word (no valid bit), then the command word 0x00000003 (query), then polls. If the completing readback has bit 2 set, the erase then writes the hash word again, writes the command word 0x00000002 (remove) and polls again. Otherwise the erase ends without further writes.
- R8: After every command write the block reads the command register (offset 0x20) repeatedly. A readback with bits 1:0 equal to zero ends the poll without error.
- R9: Poll cycles are counted from 1, starting in the cycle after the command write is acknowledged. If a readback that is still busy completes in poll cycle L or later (L being poll_limit captured with the request), the sequence ends at once with err high and makes no further bus transfers.
- R10: A request is taken only while busy is low. Its fields and poll_limit are captured at that moment. Changes to the request inputs, and req_valid pulses, while busy is high have no effect on the bus transfers.
- R11: done is high for exactly one cycle per sequence. busy is low in that cycle. err is valid while done is high.
- R12: csr_wr and csr_rd are never high together. While a transfer waits for ready, its strobe, csr_addr and (for writes) csr_wdata stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_erase | input | 1 | 0 = add filter, 1 = erase filter |
| req_src_ip | input | 32 | IPv4 source address |
| req_dst_ip | input | 32 | IPv4 destination address |
| req_src_port | input | 16 | Layer-4 source port |
| req_dst_port | input | 16 | Layer-4 destination port |
| req_flex | input | 16 | Flex bytes |
| req_ptype | input | 16 | Packet-type word |
| req_flow | input | 3 | Flow type |
| req_pool | input | 6 | Pool number |
| req_hash | input | 13 | Bucket hash |
| req_sw_idx | input | 16 | Software index |
| req_queue | input | 7 | Receive queue, 127 = drop |
| poll_limit | input | CNT_W | Poll cycle limit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Poll timeout flag, valid with done |
| csr_addr | output | ADDR_W | CSR address |
| csr_wdata | output | 32 | CSR write data |
| csr_wr | output | 1 | CSR write strobe |
| csr_rd | output | 1 | CSR read strobe |
| csr_rdata | input | 32 | CSR read data |
| csr_ready | input | 1 | CSR transfer acknowledge |

## Verification
The bench builds the block with a base address of 0x0400 and a 6-bit poll counter. With the narrow counter, limits from 0 up to the saturating value 63 can all be driven directly. Against a bus model with 0 to 2 wait states and 0 to 5 busy readbacks, this puts the timeout boundary on either side of the first, a middle and the last busy read. The sweep covers queues 0, 1, 63, 126 and the drop queue 127, every flow type, and both filter-valid answers to the erase query. It also includes a query that times out before any remove is attempted.

// File: rtl/flt_seq_pkg.sv
package flt_seq_pkg;

  localparam int WORD_W   = 32;
  localparam int QUEUE_W  = 7;
  localparam int POOL_W   = 6;
  localparam int FLOW_W   = 3;
  localparam int HASH_W   = 13;
  localparam int SWIDX_W  = 16;
  localparam int PORT_W   = 16;

  // Sequence steps; the word offset of each step is step * 4
  localparam int STEP_W      = 4;
  localparam int N_IP6_WORDS = 3;
  localparam int STEP_SA     = 3;
  localparam int STEP_DA     = 4;
  localparam int STEP_PORT   = 5;
  localparam int STEP_FLEX   = 6;
  localparam int STEP_HASH   = 7;
  localparam int STEP_CMD    = 8;
  localparam int TBL_DEPTH   = 1 << STEP_W;

  // Command word fields
  localparam logic [1:0] OPC_ADD    = 2'd1;
  localparam logic [1:0] OPC_REMOVE = 2'd2;
  localparam logic [1:0] OPC_QUERY  = 2'd3;
  localparam int OPC_LSB    = 0;
  localparam int BIT_FVALID = 2;
  localparam int BIT_UPDATE = 3;
  localparam int FLOW_LSB   = 5;
  localparam int BIT_DROP   = 9;
  localparam int BIT_LAST   = 11;
  localparam int BIT_QEN    = 15;
  localparam int QUEUE_LSB  = 16;
  localparam int POOL_LSB   = 24;

  // Hash word fields
  localparam int BIT_BKT_VALID = 15;
  localparam int SWIDX_LSB     = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_POLL  = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_ADD    = 2'd0,
    PH_QUERY  = 2'd1,
    PH_REMOVE = 2'd2
  } seq_phase_e;

  typedef struct packed {
    logic                 erase;
    logic [WORD_W-1:0]    src_ip;
    logic [WORD_W-1:0]    dst_ip;
    logic [PORT_W-1:0]    src_port;
    logic [PORT_W-1:0]    dst_port;
    logic [15:0]          flex;
    logic [15:0]          ptype;
    logic [FLOW_W-1:0]    flow;
    logic [POOL_W-1:0]    pool;
    logic [HASH_W-1:0]    hash;
    logic [SWIDX_W-1:0]   sw_idx;
    logic [QUEUE_W-1:0]   queue;
  } flt_req_t;

endpackage

// File: rtl/flt_rst_sync.sv
module flt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/flt_word_pack.sv
module flt_word_pack
  import flt_seq_pkg::*;
#(
  parameter logic [QUEUE_W-1:0] DROP_Q = 7'd127
) (
  input  seq_phase_e          phase,
  input  logic [PORT_W-1:0]   src_port,
  input  logic [PORT_W-1:0]   dst_port,
  input  logic [15:0]         flex,
  input  logic [15:0]         ptype,
  input  logic [FLOW_W-1:0]   flow,
  input  logic [POOL_W-1:0]   pool,
  input  logic [HASH_W-1:0]   hash,
  input  logic [SWIDX_W-1:0]  sw_idx,
  input  logic [QUEUE_W-1:0]  queue,
  output logic [WORD_W-1:0]   port_w,
  output logic [WORD_W-1:0]   flex_w,
  output logic [WORD_W-1:0]   hash_w,
  output logic [WORD_W-1:0]   cmd_w
);
  localparam int HASH_PAD_W = BIT_BKT_VALID - HASH_W;

  logic bkt_valid;

  assign bkt_valid = (phase == PH_ADD);
  assign port_w    = {dst_port, src_port};
  assign flex_w    = {flex, ptype};
  assign hash_w    = {sw_idx, bkt_valid, {HASH_PAD_W{1'b0}}, hash};

  always_comb begin
    cmd_w = '0;
    unique case (phase)
      PH_ADD: begin
        cmd_w[OPC_LSB +: 2]          = OPC_ADD;
        cmd_w[BIT_UPDATE]            = 1'b1;
        cmd_w[FLOW_LSB +: FLOW_W]    = flow;
        cmd_w[BIT_DROP]              = (queue == DROP_Q);
        cmd_w[BIT_LAST]              = 1'b1;
        cmd_w[BIT_QEN]               = 1'b1;
        cmd_w[QUEUE_LSB +: QUEUE_W]  = queue;
        cmd_w[POOL_LSB +: POOL_W]    = pool;
      end
      PH_QUERY:  cmd_w[OPC_LSB +: 2] = OPC_QUERY;
      PH_REMOVE: cmd_w[OPC_LSB +: 2] = OPC_REMOVE;
      default:   cmd_w = '0;
    endcase
  end
endmodule

// File: rtl/flt_step_sel.sv
module flt_step_sel
  import flt_seq_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic [STEP_W-1:0] step,
  input  logic              poll_sel,
  input  logic [WORD_W-1:0] src_ip,
  input  logic [WORD_W-1:0] dst_ip,
  input  logic [WORD_W-1:0] port_w,
  input  logic [WORD_W-1:0] flex_w,
  input  logic [WORD_W-1:0] hash_w,
  input  logic [WORD_W-1:0] cmd_w,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] wdata
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = BASE_ADDR + ADDR_W'(STEP_CMD * 4);

  logic [WORD_W-1:0] word_tbl [TBL_DEPTH];

  // Upper address words of the wide address form are always zero
  for (genvar g = 0; g < N_IP6_WORDS; g++) begin : g_ip6_zero
    assign word_tbl[g] = '0;
  end

  assign word_tbl[STEP_SA]   = src_ip;
  assign word_tbl[STEP_DA]   = dst_ip;
  assign word_tbl[STEP_PORT] = port_w;
  assign word_tbl[STEP_FLEX] = flex_w;
  assign word_tbl[STEP_HASH] = hash_w;
  assign word_tbl[STEP_CMD]  = cmd_w;

  for (genvar g = STEP_CMD + 1; g < TBL_DEPTH; g++) begin : g_pad_zero
    assign word_tbl[g] = '0;
  end

  always_comb begin
    if (poll_sel) begin
      addr  = CMD_ADDR;
      wdata = '0;
    end else begin
      addr  = BASE_ADDR + ADDR_W'({step, 2'b00});
      wdata = word_tbl[step];
    end
  end
endmodule

// File: rtl/flt_poll_timer.sv
module flt_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_ce;
  logic [CNT_W:0]   cycle_no;

  always_comb begin
    count_ce = clr || (en && (count_q != CNT_MAX));
    count_d  = clr ? '0 : count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_ce) begin
      count_q <= count_d;
    end
  end

  // Current poll cycle number, counted from one
  assign cycle_no = {1'b0, count_q} + (CNT_W+1)'(1);
  assign expired  = (cycle_no >= {1'b0, limit});
endmodule

// File: rtl/flt_cmd_seq.sv
module flt_cmd_seq
  import flt_seq_pkg::*;
#(
  parameter int                 ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = '0,
  parameter int                 CNT_W     = 16,
  parameter logic [QUEUE_W-1:0] DROP_Q    = 7'd127
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_erase,
  input  logic [WORD_W-1:0]   req_src_ip,
  input  logic [WORD_W-1:0]   req_dst_ip,
  input  logic [PORT_W-1:0]   req_src_port,
  input  logic [PORT_W-1:0]   req_dst_port,
  input  logic [15:0]         req_flex,
  input  logic [15:0]         req_ptype,
  input  logic [FLOW_W-1:0]   req_flow,
  input  logic [POOL_W-1:0]   req_pool,
  input  logic [HASH_W-1:0]   req_hash,
  input  logic [SWIDX_W-1:0]  req_sw_idx,
  input  logic [QUEUE_W-1:0]  req_queue,
  input  logic [CNT_W-1:0]    poll_limit,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [ADDR_W-1:0]   csr_addr,
  output logic [WORD_W-1:0]   csr_wdata,
  output logic                csr_wr,
  output logic                csr_rd,
  input  logic [WORD_W-1:0]   csr_rdata,
  input  logic                csr_ready
);
  logic rst_sync_n;

  seq_state_e        state_q, state_d;
  seq_phase_e        phase_q, phase_d;
  logic [STEP_W-1:0] step_q,  step_d;
  logic              done_q,  done_d;
  logic              err_q,   err_d;
  flt_req_t          req_q,   req_d;
  logic [CNT_W-1:0]  limit_q;

  logic              accept;
  logic              seq_ce;
  logic              timer_clr;
  logic              timer_en;
  logic              timer_expired;
  logic              rd_busy;
  logic              rd_fvalid;
  logic              unused_rdata;

  logic [WORD_W-1:0] port_w, flex_w, hash_w, cmd_w;

  flt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Request capture
  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    req_d.erase    = req_erase;
    req_d.src_ip   = req_src_ip;
    req_d.dst_ip   = req_dst_ip;
    req_d.src_port = req_src_port;
    req_d.dst_port = req_dst_port;
    req_d.flex     = req_flex;
    req_d.ptype    = req_ptype;
    req_d.flow     = req_flow;
    req_d.pool     = req_pool;
    req_d.hash     = req_hash;
    req_d.sw_idx   = req_sw_idx;
    req_d.queue    = req_queue;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q   <= '0;
      limit_q <= '0;
    end else if (accept) begin
      req_q   <= req_d;
      limit_q <= poll_limit;
    end
  end

  // Readback decode
  assign rd_busy      = (csr_rdata[OPC_LSB +: 2] != 2'b00);
  assign rd_fvalid    = csr_rdata[BIT_FVALID];
  assign unused_rdata = ^{csr_rdata[WORD_W-1:BIT_FVALID+1], req_q.erase};

  // Next-state logic
  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    step_d  = step_q;
    done_d  = 1'b0;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_WRITE;
          phase_d = req_erase ? PH_QUERY : PH_ADD;
          step_d  = req_erase ? STEP_W'(STEP_HASH) : '0;
          err_d   = 1'b0;
        end
      end
      ST_WRITE: begin
        if (csr_ready) begin
          if (step_q == STEP_W'(STEP_CMD)) begin
            state_d = ST_POLL;
          end else begin
            step_d = step_q + STEP_W'(1);
          end
        end
      end
      ST_POLL: begin
        if (csr_ready) begin
          if (!rd_busy) begin
            if ((phase_q == PH_QUERY) && rd_fvalid) begin
              phase_d = PH_REMOVE;
              step_d  = STEP_W'(STEP_HASH);
              state_d = ST_WRITE;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              err_d   = 1'b0;
            end
          end else if (timer_expired) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign seq_ce = accept || (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_ADD;
      step_q  <= '0;
      err_q   <= 1'b0;
    end else if (seq_ce) begin
      state_q <= state_d;
      phase_q <= phase_d;
      step_q  <= step_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  // Poll window timer
  assign timer_clr = (state_q == ST_WRITE) && (step_q == STEP_W'(STEP_CMD)) && csr_ready;
  assign timer_en  = (state_q == ST_POLL);

  flt_poll_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (timer_clr),
    .en      (timer_en),
    .limit   (limit_q),
    .expired (timer_expired)
  );

  flt_word_pack #(.DROP_Q(DROP_Q)) u_pack (
    .phase    (phase_q),
    .src_port (req_q.src_port),
    .dst_port (req_q.dst_port),
    .flex     (req_q.flex),
    .ptype    (req_q.ptype),
    .flow     (req_q.flow),
    .pool     (req_q.pool),
    .hash     (req_q.hash),
    .sw_idx   (req_q.sw_idx),
    .queue    (req_q.queue),
    .port_w   (port_w),
    .flex_w   (flex_w),
    .hash_w   (hash_w),
    .cmd_w    (cmd_w)
  );

  flt_step_sel #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_sel (
    .step     (step_q),
    .poll_sel (state_q == ST_POLL),
    .src_ip   (req_q.src_ip),
    .dst_ip   (req_q.dst_ip),
    .port_w   (port_w),
    .flex_w   (flex_w),
    .hash_w   (hash_w),
    .cmd_w    (cmd_w),
    .addr     (csr_addr),
    .wdata    (csr_wdata)
  );

  assign csr_wr = (state_q == ST_WRITE);
  assign csr_rd = (state_q == ST_POLL);
  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign err    = err_q;
endmodule

// File: rtl/flt_cmd_seq_chk.sv
module flt_cmd_seq_chk
  import flt_seq_pkg::*;
#(
  parameter int                 ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = '0,
  parameter logic [QUEUE_W-1:0] DROP_Q    = 7'd127
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              csr_wr,
  input logic              csr_rd,
  input logic              csr_ready,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [WORD_W-1:0] csr_wdata
);
  localparam logic [ADDR_W-1:0] CMD_ADDR  = BASE_ADDR + ADDR_W'(STEP_CMD * 4);
  localparam logic [ADDR_W-1:0] HASH_ADDR = BASE_ADDR + ADDR_W'(STEP_HASH * 4);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_wr && csr_rd)); // R12

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !csr_ready) |=> (csr_wr && $stable(csr_addr) && $stable(csr_wdata))); // R12

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && !csr_ready) |=> (csr_rd && $stable(csr_addr))); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(csr_wr || csr_rd)); // R1

  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && (csr_addr == CMD_ADDR) && (csr_wdata[1:0] == OPC_ADD))
      |-> (csr_wdata[BIT_DROP] == (csr_wdata[QUEUE_LSB +: QUEUE_W] == DROP_Q))); // R6

  AST_HASH_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && (csr_addr == HASH_ADDR)) |-> (csr_wdata[14:13] == 2'b00)); // R4
endmodule

bind flt_cmd_seq flt_cmd_seq_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .DROP_Q    (DROP_Q)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .csr_wr    (csr_wr),
  .csr_rd    (csr_rd),
  .csr_ready (csr_ready),
  .csr_addr  (csr_addr),
  .csr_wdata (csr_wdata)
);

// File: tb/tb_flt_cmd_seq.sv
module tb_flt_cmd_seq;
  localparam int          ADDR_W = 16;
  localparam logic [15:0] BASE   = 16'h0400;
  localparam int          CNT_W  = 6;
  localparam logic [15:0] CMD_A  = BASE + 16'h0020;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_erase;
  logic [31:0] req_src_ip, req_dst_ip;
  logic [15:0] req_src_port, req_dst_port, req_flex, req_ptype, req_sw_idx;
  logic [2:0]  req_flow;
  logic [5:0]  req_pool;
  logic [12:0] req_hash;
  logic [6:0]  req_queue;
  logic [CNT_W-1:0] poll_limit;
  logic        busy, done, err;
  logic [15:0] csr_addr;
  logic [31:0] csr_wdata, csr_rdata;
  logic        csr_wr, csr_rd, csr_ready;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flt_cmd_seq #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
    .req_src_ip(req_src_ip), .req_dst_ip(req_dst_ip),
    .req_src_port(req_src_port), .req_dst_port(req_dst_port),
    .req_flex(req_flex), .req_ptype(req_ptype), .req_flow(req_flow),
    .req_pool(req_pool), .req_hash(req_hash), .req_sw_idx(req_sw_idx),
    .req_queue(req_queue), .poll_limit(poll_limit),
    .busy(busy), .done(done), .err(err),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_rdata(csr_rdata), .csr_ready(csr_ready)
  );

  // CSR target model, all activity on the falling edge
  int          cfg_wait = 0, cfg_busy = 0, cfg_valid = 0;
  int          wcnt = 0, busy_left = 0;
  logic [31:0] last_cmd = 32'h0;
  logic [15:0] log_a [32];
  logic [31:0] log_d [32];
  int          wlog_n = 0, rlog_n = 0, bad_rd = 0, hold_bad = 0;
  logic        p_act = 1'b0, p_ready = 1'b0, p_wr = 1'b0;
  logic [15:0] p_addr = 16'h0;
  logic [31:0] p_data = 32'h0;

  always @(negedge clk) begin
    if (csr_wr && csr_rd) hold_bad++;
    if (p_act && !p_ready) begin
      if (!(csr_wr || csr_rd) || (csr_wr != p_wr) || (csr_addr != p_addr) ||
          (p_wr && (csr_wdata != p_data)))
        hold_bad++;
    end
    if (csr_wr || csr_rd) begin
      if (wcnt >= cfg_wait) begin
        csr_ready = 1'b1;
        wcnt = 0;
        if (csr_wr) begin
          if (wlog_n < 32) begin
            log_a[wlog_n] = csr_addr;
            log_d[wlog_n] = csr_wdata;
          end
          wlog_n++;
          if (csr_addr == CMD_A) begin
            busy_left = cfg_busy;
            last_cmd  = csr_wdata;
          end
        end else begin
          rlog_n++;
          if (csr_addr != CMD_A) bad_rd++;
          if (busy_left > 0) begin
            csr_rdata = last_cmd;
            busy_left--;
          end else begin
            csr_rdata = {last_cmd[31:3], (cfg_valid != 0), 2'b00};
          end
        end
      end else begin
        csr_ready = 1'b0;
        wcnt++;
      end
    end else begin
      csr_ready = 1'b0;
      wcnt = 0;
    end
    p_act   = csr_wr || csr_rd;
    p_ready = csr_ready;
    p_wr    = csr_wr;
    p_addr  = csr_addr;
    p_data  = csr_wdata;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected transfer list
  logic [15:0] exp_a [32];
  logic [31:0] exp_d [32];
  string       exp_t [32];
  int          exp_n, exp_reads;
  bit          exp_err;

  task automatic push(input logic [15:0] a, input logic [31:0] d, input string t);
    exp_a[exp_n] = a;
    exp_d[exp_n] = d;
    exp_t[exp_n] = t;
    exp_n++;
  endtask

  task automatic poll_res(input int b, input int w, input int l,
                          output int reads, output bit to);
    to = 0;
    reads = b + 1;
    for (int n = 1; n <= b; n++) begin
      if (!to && (n * (w + 1) >= l)) begin
        to = 1;
        reads = n;
      end
    end
  endtask

  task automatic build_exp(input int w, input int b, input int v, input int l);
    logic [31:0] hw, cw;
    int rd;
    bit to;
    exp_n = 0;
    exp_reads = 0;
    exp_err = 0;
    if (!req_erase) begin
      for (int k = 0; k < 3; k++) push(BASE + 16'(k * 4), 32'h0, "R2");
      push(BASE + 16'h0C, req_src_ip, "R2");
      push(BASE + 16'h10, req_dst_ip, "R2");
      push(BASE + 16'h14, {req_dst_port, req_src_port}, "R3");
      push(BASE + 16'h18, {req_flex, req_ptype}, "R3");
      hw = {req_sw_idx, 1'b1, 2'b00, req_hash};
      push(BASE + 16'h1C, hw, "R4");
      cw = 32'h1 | 32'h8 | ({29'h0, req_flow} << 5) | 32'h800 | 32'h8000 |
           ({25'h0, req_queue} << 16) | ({26'h0, req_pool} << 24);
      if (req_queue == 7'd127) cw = cw | 32'h200;
      push(CMD_A, cw, (req_queue == 7'd127 || req_queue == 7'd126) ? "R6" : "R5");
      poll_res(b, w, l, rd, to);
      exp_reads = rd;
      exp_err = to;
    end else begin
      hw = {req_sw_idx, 1'b0, 2'b00, req_hash};
      push(BASE + 16'h1C, hw, "R4");
      push(CMD_A, 32'h3, "R7");
      poll_res(b, w, l, rd, to);
      exp_reads = rd;
      exp_err = to;
      if (!to && v != 0) begin
        push(BASE + 16'h1C, hw, "R7");
        push(CMD_A, 32'h2, "R7");
        poll_res(b, w, l, rd, to);
        exp_reads += rd;
        exp_err = to;
      end
    end
  endtask

  task automatic do_run(input string tag, input int w, input int b, input int v,
                        input int l, input bit inject);
    int n;
    @(negedge clk);
    cfg_wait = w; cfg_busy = b; cfg_valid = v;
    poll_limit = CNT_W'(l);
    build_exp(w, b, v, l);
    wlog_n = 0; rlog_n = 0; bad_rd = 0; hold_bad = 0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", {tag, " busy after request"}, 64'(busy), 64'd1);
    if (inject) begin
      req_src_ip = ~req_src_ip; req_queue = ~req_queue; req_hash = ~req_hash;
      req_erase = ~req_erase; poll_limit = '0;
      req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk("R8", {tag, " done seen"}, 64'(done), 64'd1);
    chk("R11", {tag, " busy low with done"}, 64'(busy), 64'd0);
    chk("R9", {tag, " err"}, 64'(err), 64'(exp_err));
    chk(inject ? "R10" : "R2", {tag, " write count"}, 64'(wlog_n), 64'(exp_n));
    for (int k = 0; k < exp_n && k < 32; k++) begin
      chk(exp_t[k], $sformatf("%s addr[%0d]", tag, k), 64'(log_a[k]), 64'(exp_a[k]));
      chk(exp_t[k], $sformatf("%s data[%0d]", tag, k), 64'(log_d[k]), 64'(exp_d[k]));
    end
    chk(exp_err ? "R9" : "R8", {tag, " read count"}, 64'(rlog_n), 64'(exp_reads));
    chk("R8", {tag, " reads at command address"}, 64'(bad_rd), 64'd0);
    chk("R12", {tag, " bus hold"}, 64'(hold_bad), 64'd0);
    @(negedge clk);
    chk("R11", {tag, " done one cycle"}, 64'(done), 64'd0);
    chk("R11", {tag, " idle after"}, 64'(busy), 64'd0);
    chk("R9", {tag, " no transfer after end"}, 64'(csr_wr || csr_rd), 64'd0);
  endtask

  task automatic set_fields(input int idx, input bit erase, input logic [6:0] q);
    req_erase    = erase;
    req_src_ip   = 32'hC0A8_0000 + 32'(idx * 17);
    req_dst_ip   = 32'h0A00_0001 ^ (32'(idx) << 8);
    req_src_port = 16'h1000 + 16'(idx);
    req_dst_port = 16'hFFFF - 16'(idx * 3);
    req_flex     = 16'h8100 + 16'(idx);
    req_ptype    = 16'h0011 + 16'(idx);
    req_flow     = 3'(idx % 8);
    req_pool     = 6'((idx * 7) % 64);
    req_hash     = 13'((idx * 911) % 8192);
    req_sw_idx   = 16'hA000 + 16'(idx * 5);
    req_queue    = q;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [6:0] qs [5];
    int idx;
    qs[0] = 7'd0; qs[1] = 7'd1; qs[2] = 7'd63; qs[3] = 7'd126; qs[4] = 7'd127;
    rst_n = 1'b0;
    req_valid = 1'b0;
    set_fields(0, 1'b0, 7'd0);
    poll_limit = '1;
    csr_rdata = 32'h0;
    csr_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "busy after reset", 64'(busy), 64'd0);
    chk("R1", "done after reset", 64'(done), 64'd0);
    chk("R1", "strobes after reset", 64'({csr_wr, csr_rd}), 64'd0);

    // Add sweep over queues, wait states and busy readbacks
    idx = 1;
    for (int qi = 0; qi < 5; qi++) begin
      for (int wi = 0; wi < 2; wi++) begin
        for (int bi = 0; bi < 2; bi++) begin
          set_fields(idx, 1'b0, qs[qi]);
          do_run($sformatf("add%0d", idx), wi * 2, bi * 3, 0, 63, 1'b0);
          idx++;
        end
      end
    end

    // Erase sweep over the filter-valid answer
    for (int v = 0; v < 2; v++) begin
      for (int wi = 0; wi < 2; wi++) begin
        for (int bi = 0; bi < 2; bi++) begin
          set_fields(idx, 1'b1, 7'd9);
          do_run($sformatf("erase%0d_v%0d", idx, v), wi, bi * 2, v, 63, 1'b0);
          idx++;
        end
      end
    end

    // Timeout boundary sweep
    for (int wi = 0; wi < 2; wi++) begin
      for (int li = 0; li < 6; li++) begin
        int lims [6];
        lims[0] = 0; lims[1] = 1; lims[2] = 3; lims[3] = 6; lims[4] = 11; lims[5] = 12;
        set_fields(idx, 1'b0, 7'd127);
        do_run($sformatf("timeout%0d_L%0d", idx, lims[li]), wi, 5, 0, lims[li], 1'b0);
        idx++;
      end
    end
    set_fields(idx, 1'b1, 7'd3);
    do_run("erase_query_timeout", 0, 3, 1, 2, 1'b0);
    idx++;
    set_fields(idx, 1'b1, 7'd3);
    do_run("erase_both_polls", 0, 3, 1, 4, 1'b0);
    idx++;

    // Request inputs disturbed while busy
    set_fields(idx, 1'b0, 7'd127);
    do_run("inject", 1, 2, 0, 63, 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule